// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Counter

This block is the counting engine of a single timer channel. On every system clock it chooses a primary count source and a secondary source. The primary source is one of four input pins, one of four neighbouring counter outputs, or a power-of-two division of the system clock. The engine then advances a 16-bit counter according to one of eight counting modes, which can be changed at run time. The modes cover single-edge counting, double-edge counting, secondary-gated counting, quadrature decoding, counting with the direction set by the secondary source, counting armed by a trigger and stopped at compare, and cascade counting from a neighbour.

When the counter reaches the active compare value it reloads from a load register. Counting up compares against the first compare register; counting down compares against the second. Each compare register can be refreshed from a preload register on a chosen compare event. Sticky status flags record compare, overflow and secondary-edge events, and an interrupt line combines them with per-flag enables. The channel is configured through a plain write-only register port. A debug input can freeze the counter and silence the compare pulse.

All inputs are taken as already synchronous to the system clock. Edges are found by comparing each source with its value on the previous clock.

Top module: `tmr_chan_engine`

## Requirements
- R1: After reset, `count_o` is 0, `flags_o` is 0, `irq_o` is 0 and `cmp_o` is 0, with the counting mode set to stop.
- R2: Primary source code 0-3 picks `pin_i[code]`, code 4-7 picks `chan_i[code-4]`, and code 8-15 picks an internal tick that pulses once every 2^(code-8) clocks (code 8 means every clock). A tick source counts one step per pulse in every edge-based mode.
- R3: Mode 0 holds the counter. Leaving mode 0 resumes counting from the held value, and all other settings are kept.
- R4: Mode 1 steps on each rising edge of the primary source. Mode 2 steps on both its rising and falling edges. Both modes use the direction bit, where 0 means up and 1 means down.
- R5: Mode 3 counts primary rising edges only while the secondary pin is high. Mode 5 counts primary rising edges downward while the secondary pin is high and upward while it is low.
- R6: Mode 4 treats {primary, secondary} as a quadrature pair. The steps 00→01→11→10→00 each count up by one, the reverse steps each count down by one, and a change of both bits at once leaves the count unchanged.
- R7: Mode 6 ignores primary edges until a rising edge on the secondary pin arms it. It then counts primary rising edges until a compare match, reloads, and disarms.
- R8: Mode 7 counts one step on every clock in which the primary source is high, using the direction bit.
- R9: On a counting step upward with count equal to compare-1, the counter loads the load register and sets flag bits 1 and 0. On a counting step downward with count equal to compare-2, it loads the load register and sets flag bits 2 and 0. In either case `cmp_o` is high for the following cycle.
- R10: A step up from 0xFFFF gives 0x0000, and a step down from 0x0000 gives 0xFFFF. Either wrap sets flag bit 3, unless the step was a compare match.
- R11: Preload field code 1 copies a preload value into its compare register on a compare-1 match, and code 2 does so on a compare-2 match. Codes 0 and 3 never copy.
- R12: A rising edge on the selected secondary pin sets flag bit 4 in any mode. Flags stay set until a write to address 7 clears each bit written as 1, and a new event in the same cycle wins over the clear. `irq_o` is high when any flag is set together with its enable bit.
- R13: With `dbg_i` high, control bit 14 freezes the counter and control bit 15 holds `cmp_o` low.
- R14: Register write addresses are as follows:
  - 0: control, with psrc [3:0], ssrc [5:4], mode [8:6], down [9], preload-1 [11:10], preload-2 [13:12], debug [15:14]
  - 1: load
  - 2: compare-1
  - 3: compare-2
  - 4: preload-1
  - 5: preload-2
  - 6: counter (this write overrides counting in that cycle)
  - 7: flag clear
  - 8: interrupt enable [4:0]

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | External input pins, synchronous to clk |
| chan_i | input | 4 | Outputs of the neighbouring counters |
| dbg_i | input | 1 | Debug state of the system |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 16 | Register write data |
| count_o | output | 16 | Current counter value |
| flags_o | output | 5 | Status flags: compare, compare-1, compare-2, overflow, secondary edge |
| irq_o | output | 1 | Interrupt request |
| cmp_o | output | 1 | One-cycle compare pulse |

## Verification
The assertions assume that all inputs change only between clock edges and are already synchronous. They also assume that writes to the counter address are the only source of count changes other than the counting modes. The bench therefore drives every input one time unit after a rising edge. It holds each input level for at least one full clock, so that each intended edge is seen exactly once. The prescaler tests never rely on the tick phase. They count over a whole number of tick periods, so each window holds a fixed number of ticks whatever the starting phase.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [2:0] {
        MD_STOP  = 3'd0,
        MD_RISE  = 3'd1,
        MD_BOTH  = 3'd2,
        MD_GATED = 3'd3,
        MD_QUAD  = 3'd4,
        MD_DIR   = 3'd5,
        MD_TRIG  = 3'd6,
        MD_CASC  = 3'd7
    } cnt_mode_e;

    typedef enum logic [1:0] {
        PL_NONE    = 2'd0,
        PL_ON_CMP1 = 2'd1,
        PL_ON_CMP2 = 2'd2,
        PL_RSVD    = 2'd3
    } preload_e;

    typedef struct packed {
        logic      dbg_force;  // 15
        logic      dbg_halt;   // 14
        preload_e  pl2;        // 13:12
        preload_e  pl1;        // 11:10
        logic      down;       // 9
        cnt_mode_e mode;       // 8:6
        logic [1:0] ssrc;      // 5:4
        logic [3:0] psrc;      // 3:0
    } ctrl_t;

    localparam int FLG_W    = 5;
    localparam int FLG_CMP  = 0;
    localparam int FLG_CMP1 = 1;
    localparam int FLG_CMP2 = 2;
    localparam int FLG_OVF  = 3;
    localparam int FLG_EDGE = 4;

    localparam int RA_CTRL = 0;
    localparam int RA_LOAD = 1;
    localparam int RA_CMP1 = 2;
    localparam int RA_CMP2 = 3;
    localparam int RA_PRE1 = 4;
    localparam int RA_PRE2 = 5;
    localparam int RA_CNT  = 6;
    localparam int RA_CLR  = 7;
    localparam int RA_IEN  = 8;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter  int STAGES = 8,
    localparam int DIV_W  = (STAGES > 1) ? STAGES - 1 : 1,
    localparam int SEL_W  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    logic [DIV_W-1:0]  div_d, div_q;
    logic [STAGES-1:0] taps;

    always_comb begin
        div_d = div_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign taps[0] = 1'b1;
    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_tap
            assign taps[k] = &div_q[k-1:0];
        end
    endgenerate

    assign tick_o = taps[sel_i];
endmodule

// File: rtl/tmr_quad.sv
module tmr_quad (
    input  logic [1:0] prev_i,
    input  logic [1:0] now_i,
    output logic       step_o,
    output logic       down_o
);
    function automatic logic [1:0] phase(input logic [1:0] ab);
        return {ab[1], ab[1] ^ ab[0]};
    endfunction

    logic [1:0] delta;

    always_comb begin
        delta  = phase(now_i) - phase(prev_i);
        step_o = (delta == 2'd1) || (delta == 2'd3);
        down_o = (delta == 2'd3);
    end
endmodule

// File: rtl/tmr_event.sv
module tmr_event
    import tmr_chan_pkg::*;
#(
    parameter  int N_PIN  = 4,
    parameter  int N_CHAN = 4,
    localparam int N_SRC  = N_PIN + N_CHAN,
    localparam int SRC_IW = $clog2(N_SRC)
) (
    input  ctrl_t              ctrl_i,
    input  logic [N_SRC-1:0]   now_i,
    input  logic [N_SRC-1:0]   prev_i,
    input  logic               tick_i,
    input  logic               run_i,
    output logic               evt_o,
    output logic               down_o,
    output logic               sec_rise_o
);
    logic [SRC_IW-1:0] p_idx, s_idx;
    logic p_now, p_prev, s_now, s_prev, from_pin;
    logic p_rise, p_both, p_lvl;
    logic q_step, q_down;

    always_comb begin
        p_idx    = ctrl_i.psrc[SRC_IW-1:0];
        s_idx    = SRC_IW'(ctrl_i.ssrc);
        p_now    = now_i[p_idx];
        p_prev   = prev_i[p_idx];
        s_now    = now_i[s_idx];
        s_prev   = prev_i[s_idx];
        from_pin = int'(ctrl_i.psrc) < N_SRC;
        p_rise   = from_pin ? (p_now & ~p_prev) : tick_i;
        p_both   = from_pin ? (p_now ^ p_prev)  : tick_i;
        p_lvl    = from_pin ? p_now : tick_i;
    end

    tmr_quad u_quad (
        .prev_i ({p_prev, s_prev}),
        .now_i  ({p_now, s_now}),
        .step_o (q_step),
        .down_o (q_down)
    );

    always_comb begin
        evt_o      = 1'b0;
        down_o     = ctrl_i.down;
        sec_rise_o = s_now & ~s_prev;
        unique case (ctrl_i.mode)
            MD_STOP:  evt_o = 1'b0;
            MD_RISE:  evt_o = p_rise;
            MD_BOTH:  evt_o = p_both;
            MD_GATED: evt_o = p_rise & s_now;
            MD_QUAD: begin
                evt_o  = q_step;
                down_o = q_down;
            end
            MD_DIR: begin
                evt_o  = p_rise;
                down_o = s_now;
            end
            MD_TRIG:  evt_o = p_rise & run_i;
            MD_CASC:  evt_o = p_lvl;
            default:  evt_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_chan_engine.sv
module tmr_chan_engine
    import tmr_chan_pkg::*;
#(
    parameter  int CNT_W      = 16,
    parameter  int N_PIN      = 4,
    parameter  int N_CHAN     = 4,
    parameter  int ADDR_W     = 4,
    parameter  int PSC_STAGES = 8,
    localparam int N_SRC      = N_PIN + N_CHAN,
    localparam int SEL_W      = (PSC_STAGES > 1) ? $clog2(PSC_STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PIN-1:0]  pin_i,
    input  logic [N_CHAN-1:0] chan_i,
    input  logic              dbg_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [FLG_W-1:0]  flags_o,
    output logic              irq_o,
    output logic              cmp_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  load;
        logic [CNT_W-1:0]  cmp1;
        logic [CNT_W-1:0]  cmp2;
        logic [CNT_W-1:0]  pre1;
        logic [CNT_W-1:0]  pre2;
        logic [CNT_W-1:0]  cnt;
        logic [FLG_W-1:0]  flags;
        logic [FLG_W-1:0]  ien;
        logic [N_SRC-1:0]  src;
        logic              run;
        logic              cmp_pls;
    } state_t;

    state_t st_d, st_q;

    logic [N_SRC-1:0] raw_now;
    logic tick, ev_evt, ev_down, sec_rise;
    logic evt, hit1, hit2, ovf;
    logic [FLG_W-1:0] set_vec;

    // signals seen by the bound checker
    logic [2:0] cur_mode;
    logic [1:0] cur_dbg;

    assign raw_now = {chan_i, pin_i};

    tmr_prescale #(.STAGES(PSC_STAGES)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (st_q.ctrl.psrc[SEL_W-1:0]),
        .tick_o (tick)
    );

    tmr_event #(.N_PIN(N_PIN), .N_CHAN(N_CHAN)) u_evt (
        .ctrl_i     (st_q.ctrl),
        .now_i      (raw_now),
        .prev_i     (st_q.src),
        .tick_i     (tick),
        .run_i      (st_q.run),
        .evt_o      (ev_evt),
        .down_o     (ev_down),
        .sec_rise_o (sec_rise)
    );

    always_comb begin
        st_d     = st_q;
        st_d.src = raw_now;

        evt  = ev_evt & ~(dbg_i & st_q.ctrl.dbg_halt);
        hit1 = evt & ~ev_down & (st_q.cnt == st_q.cmp1);
        hit2 = evt &  ev_down & (st_q.cnt == st_q.cmp2);
        ovf  = 1'b0;

        if (hit1 || hit2) begin
            st_d.cnt = st_q.load;
        end else if (evt && ev_down) begin
            ovf      = (st_q.cnt == '0);
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end else if (evt) begin
            ovf      = (st_q.cnt == '1);
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        set_vec           = '0;
        set_vec[FLG_CMP]  = hit1 | hit2;
        set_vec[FLG_CMP1] = hit1;
        set_vec[FLG_CMP2] = hit2;
        set_vec[FLG_OVF]  = ovf;
        set_vec[FLG_EDGE] = sec_rise;

        if (st_q.ctrl.mode != MD_TRIG || hit1 || hit2) st_d.run = 1'b0;
        else if (sec_rise)                             st_d.run = 1'b1;

        if ((st_q.ctrl.pl1 == PL_ON_CMP1 && hit1) || (st_q.ctrl.pl1 == PL_ON_CMP2 && hit2))
            st_d.cmp1 = st_q.pre1;
        if ((st_q.ctrl.pl2 == PL_ON_CMP1 && hit1) || (st_q.ctrl.pl2 == PL_ON_CMP2 && hit2))
            st_d.cmp2 = st_q.pre2;

        st_d.cmp_pls = (hit1 | hit2) & ~(dbg_i & st_q.ctrl.dbg_force);

        if (wr_en_i) begin
            unique case (int'(wr_addr_i))
                RA_CTRL: st_d.ctrl  = ctrl_t'(wr_data_i[15:0]);
                RA_LOAD: st_d.load  = wr_data_i;
                RA_CMP1: st_d.cmp1  = wr_data_i;
                RA_CMP2: st_d.cmp2  = wr_data_i;
                RA_PRE1: st_d.pre1  = wr_data_i;
                RA_PRE2: st_d.pre2  = wr_data_i;
                RA_CNT:  st_d.cnt   = wr_data_i;
                RA_CLR:  st_d.flags = st_q.flags & ~wr_data_i[FLG_W-1:0];
                RA_IEN:  st_d.ien   = wr_data_i[FLG_W-1:0];
                default: ;
            endcase
        end
        st_d.flags = st_d.flags | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o  = st_q.cnt;
    assign flags_o  = st_q.flags;
    assign irq_o    = |(st_q.flags & st_q.ien);
    assign cmp_o    = st_q.cmp_pls;
    assign cur_mode = st_q.ctrl.mode;
    assign cur_dbg  = {st_q.ctrl.dbg_force, st_q.ctrl.dbg_halt};
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int FLG_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dbg_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [2:0]        cur_mode,
    input logic [1:0]        cur_dbg,
    input logic [CNT_W-1:0]  count_o,
    input logic [FLG_W-1:0]  flags_o,
    input logic              cmp_o
);
    logic cnt_wr, clr_wr;
    assign cnt_wr = wr_en_i && (wr_addr_i == ADDR_W'(6));
    assign clr_wr = wr_en_i && (wr_addr_i == ADDR_W'(7));

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd0 && !cnt_wr) |=> $stable(count_o));

    // R13
    dbg_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_i && cur_dbg[0] && !cnt_wr) |=> $stable(count_o));

    // R13
    dbg_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_i && cur_dbg[1]) |=> !cmp_o);

    // R12
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // R9
    cmp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[0]) |-> (flags_o[1] || flags_o[2]));

    // R9
    cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_o |-> flags_o[0]);
endmodule

bind tmr_chan_engine tmr_chan_chk #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W),
    .FLG_W (tmr_chan_pkg::FLG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_i    (dbg_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .cur_mode (cur_mode),
    .cur_dbg  (cur_dbg),
    .count_o  (count_o),
    .flags_o  (flags_o),
    .cmp_o    (cmp_o)
);

// File: tb/tmr_chan_engine_tb.sv
`timescale 1ns/1ps
module tmr_chan_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin = '0;
    logic [3:0]  chan = '0;
    logic        dbg = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic [4:0]  flags;
    logic        irq, cmp;

    always #2.5 clk = ~clk;

    tmr_chan_engine u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .chan_i(chan), .dbg_i(dbg),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .count_o(count), .flags_o(flags), .irq_o(irq), .cmp_o(cmp)
    );

    typedef struct {
        string       tag;
        logic [15:0] cnt;
        logic [4:0]  flg;
        logic        irq;
        logic        cmp;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [4:0] ien_m = '0;

    function automatic logic [15:0] mk(input int psrc, input int ssrc, input int mode,
                                       input int dn, input int pl1, input int pl2, input int dbgc);
        return {2'(dbgc), 2'(pl2), 2'(pl1), 1'(dn), 3'(mode), 2'(ssrc), 4'(psrc)};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input int n);
        repeat (n) step();
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_pin(input int i);
        pin[i] = 1'b1; step();
        pin[i] = 1'b0; step();
    endtask

    task automatic pulse_chan(input int i);
        chan[i] = 1'b1; step();
        chan[i] = 1'b0; step();
    endtask

    // driver side: push one expectation
    task automatic expect_now(input string tag, input int c, input int f, input bit cp);
        exp_t e;
        e.tag = tag; e.cnt = 16'(c); e.flg = 5'(f); e.cmp = cp;
        e.irq = |(5'(f) & ien_m);
        sb_q.push_back(e);
    endtask

    // monitor side
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (count !== e.cnt || flags !== e.flg || irq !== e.irq || cmp !== e.cmp) begin
                    n_fail++;
                    $display("FAIL %s: count=%0d exp %0d flags=%h exp %h irq=%b exp %b cmp=%b exp %b",
                             e.tag, count, e.cnt, flags, e.flg, irq, e.irq, cmp, e.cmp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run=hung exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        run(4);
        rst_n = 1'b1;
        step();
        expect_now("R1 reset state", 0, 0, 0);

        // R14 register map used throughout
        wr(2, 100);
        wr(0, mk(0, 1, 1, 0, 0, 0, 0));
        for (int i = 0; i < 3; i++) pulse_pin(0);
        expect_now("R4 mode1 rising", 3, 0, 0);
        wr(0, mk(0, 1, 2, 0, 0, 0, 0));
        for (int i = 0; i < 2; i++) pulse_pin(0);
        expect_now("R4 mode2 both edges", 7, 0, 0);

        wr(0, mk(0, 1, 0, 0, 0, 0, 0));
        pulse_pin(0); pulse_pin(0);
        expect_now("R3 stop holds", 7, 0, 0);
        wr(0, mk(0, 1, 1, 0, 0, 0, 0));
        pulse_pin(0);
        expect_now("R3 resume", 8, 0, 0);

        wr(0, mk(4, 1, 1, 0, 0, 0, 0));
        pulse_chan(0);
        pulse_pin(0);
        expect_now("R2 neighbour source, pin ignored", 9, 0, 0);

        wr(0, mk(10, 1, 1, 0, 0, 0, 0));
        run(15);
        wr(0, mk(8, 1, 1, 0, 0, 0, 0));
        expect_now("R2 divide by 4 over 16 clocks", 13, 0, 0);
        run(9);
        wr(0, mk(15, 1, 1, 0, 0, 0, 0));
        expect_now("R2 divide by 1 over 10 clocks", 23, 0, 0);
        run(255);
        wr(0, mk(0, 1, 0, 0, 0, 0, 0));
        expect_now("R2 divide by 128 over 256 clocks", 25, 0, 0);

        wr(0, mk(0, 1, 3, 0, 0, 0, 0));
        pulse_pin(0);
        expect_now("R5 gated low", 25, 0, 0);
        pin[1] = 1'b1; run(1);
        pulse_pin(0); pulse_pin(0);
        expect_now("R5 gated high, R12 edge flag", 27, 5'h10, 0);
        wr(7, 5'h1f);
        expect_now("R12 clear", 27, 0, 0);

        wr(0, mk(0, 1, 5, 0, 0, 0, 0));
        pulse_pin(0); pulse_pin(0);
        expect_now("R5 secondary high counts down", 25, 0, 0);
        pin[1] = 1'b0; run(1);
        pulse_pin(0);
        expect_now("R5 secondary low counts up", 26, 0, 0);

        wr(0, mk(0, 1, 4, 0, 0, 0, 0));
        pin[1] = 1'b1; run(1);
        pin[0] = 1'b1; run(1);
        pin[1] = 1'b0; run(1);
        pin[0] = 1'b0; run(1);
        expect_now("R6 quadrature forward", 30, 5'h10, 0);
        pin[0] = 1'b1; run(1);
        pin[1] = 1'b1; run(1);
        pin[0] = 1'b0; pin[1] = 1'b0; run(1);
        expect_now("R6 quadrature reverse and double change", 28, 5'h10, 0);
        wr(7, 5'h1f);

        wr(0, mk(0, 1, 1, 0, 0, 0, 0));
        wr(1, 20);
        wr(2, 18);
        wr(6, 16);
        pulse_pin(0);
        pin[0] = 1'b1; step(); pin[0] = 1'b0; step();
        pin[0] = 1'b1; step();
        expect_now("R9 up match reloads, pulse", 20, 5'h03, 1);
        pin[0] = 1'b0; run(1);
        expect_now("R9 pulse one cycle", 20, 5'h03, 0);

        wr(7, 5'h1f);
        wr(3, 500);
        wr(0, mk(0, 1, 1, 1, 0, 0, 0));
        wr(6, 1);
        pulse_pin(0); pulse_pin(0);
        expect_now("R10 down wrap overflow", 16'hffff, 5'h08, 0);
        wr(6, 502);
        for (int i = 0; i < 3; i++) pulse_pin(0);
        expect_now("R9 down match on compare-2", 20, 5'h0d, 0);

        wr(0, mk(5, 1, 7, 0, 0, 0, 0));
        chan[1] = 1'b1; run(3); chan[1] = 1'b0; run(1);
        expect_now("R8 cascade level count", 23, 5'h0d, 0);

        wr(7, 5'h1f);
        wr(4, 30);
        wr(0, mk(0, 1, 1, 0, 1, 0, 0));
        wr(6, 17);
        pulse_pin(0); pulse_pin(0);
        expect_now("R11 match with old compare-1", 20, 5'h03, 0);
        wr(6, 29);
        pulse_pin(0); pulse_pin(0);
        expect_now("R11 preloaded compare-1 used", 20, 5'h03, 0);

        wr(7, 5'h1f);
        wr(0, mk(0, 1, 6, 0, 0, 0, 0));
        wr(6, 27);
        pulse_pin(0);
        expect_now("R7 not armed", 27, 0, 0);
        pin[1] = 1'b1; run(1);
        for (int i = 0; i < 5; i++) pulse_pin(0);
        expect_now("R7 counts to compare then stops", 20, 5'h13, 0);

        wr(8, 5'h02); ien_m = 5'h02;
        expect_now("R12 irq enabled", 20, 5'h13, 0);
        wr(7, 5'h02);
        expect_now("R12 write one clears only that bit", 20, 5'h11, 0);

        wr(0, mk(0, 1, 1, 0, 0, 0, 1));
        dbg = 1'b1;
        pulse_pin(0);
        expect_now("R13 halt in debug", 20, 5'h11, 0);
        dbg = 1'b0;
        pulse_pin(0);
        expect_now("R13 runs outside debug", 21, 5'h11, 0);

        wr(0, mk(0, 1, 1, 0, 0, 0, 2));
        wr(6, 29);
        dbg = 1'b1;
        pin[0] = 1'b1; step(); pin[0] = 1'b0; step();
        pin[0] = 1'b1; step();
        expect_now("R13 forced compare pulse low", 20, 5'h13, 0);
        pin[0] = 1'b0; dbg = 1'b0; run(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule